// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Level Stacking

The block arbitrates eight level-sensitive hardware requests, a software-raised request and a non-maskable input against the processor's current priority level. When a candidate outranks that level, it raises a service request to the core. The core saves its context and then pulses an acknowledge. At that moment the controller picks the winner, returns its identifier, raises the processor level to the winner's level and pushes the old level onto an internal stack.

A return pulse from the core pops the saved level. If a pending request outranks the level that is about to be restored, the controller hands it straight to the core instead. The level is not restored and saved again, and the stack depth stays the same. Because the winner is only chosen at acknowledge time, a higher request that arrives while the core is still saving context is the one that gets serviced.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `irq` is high exactly when the best pending candidate's level is strictly greater than `cur_lvl`. A hardware source with level 0 never requests. Source and software levels above 8 act as 8.
- R2: An acknowledge while `irq` is high makes `ack_id` show the winner in that cycle. Hardware sources use identifiers 0 to 7, software uses 8 and the non-maskable input uses 9. From the next cycle `cur_lvl` equals the winner's level. Among equal levels, the lowest identifier wins.
- R3: Each acceptance pushes the previous `cur_lvl` onto the stack. Each return that does not chain pops the stack into `cur_lvl`, in last-in first-out order, through nine nesting levels.
- R4: The non-maskable input has level 9 and wins over every other candidate. It requests at any `cur_lvl` up to 8. It does not request again while `cur_lvl` is 9.
- R5: Arbitration happens in the acknowledge cycle. A higher request that appears after `irq` rose, but before the acknowledge, is the one accepted.
- R6: A `sw_wr` pulse makes the software request pending at level `sw_lvl`; writing level 0 cancels it. Accepting the software request clears it, whether by acknowledge or by chaining. Accepting a hardware source does not clear it: the source stays pending while its input is high.
- R7: On a return with a non-empty stack, if the winner's level exceeds the top saved level, `chain` is high in that cycle and `ack_id` shows the winner. `cur_lvl` then becomes the winner's level and the stack is left unchanged. Otherwise `chain` stays low and the level is popped.
- R8: An acknowledge while `irq` is low shows `ack_id` 15 and changes nothing. A return with an empty stack changes nothing. A return in the same cycle as an acknowledge is ignored. Outside an accepting or chaining cycle, `ack_id` is 15.
- R9: After reset `cur_lvl` is 0, the stack is empty, no software request is pending, and `irq` and `chain` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 8 | Level-sensitive hardware requests |
| src_lvl | input | 32 | Level of each source, 4 bits per source, source 0 in the low bits |
| nmi | input | 1 | Non-maskable request, level-sensitive |
| sw_wr | input | 1 | Write strobe for the software request |
| sw_lvl | input | 4 | Level for the software request, 0 cancels it |
| ack | input | 1 | Acknowledge pulse from the core after its context is saved |
| ret | input | 1 | Handler return pulse from the core |
| irq | output | 1 | Service request to the core |
| ack_id | output | 4 | Identifier accepted in this cycle, 15 when none |
| chain | output | 1 | The return in this cycle chains to a new handler |
| cur_lvl | output | 4 | Current processor priority level |

## Verification
Every request pattern is swept at every processor level against a fixed set of source levels. That set includes ties, a disabled source and a level that saturates. A design that compares with greater-or-equal, or breaks ties toward the higher index, fails this sweep. The bench raises a higher request between the rise of `irq` and the acknowledge, which catches a design that latches its winner early. Returns are issued with pending work that is just above, equal to, or below the restored level, which catches chaining on the wrong level or a stack that is popped during a chain. The bench also nests all nine levels and then unwinds them, which exposes a stack that loses ordering. Finally it checks that a non-maskable request is not re-entered while it is being serviced.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 8,
  parameter int PW   = 4,
  parameter int IDW  = $clog2(NSRC + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req,
  input  logic [NSRC*PW-1:0] src_lvl,
  input  logic              nmi,
  input  logic              sw_wr,
  input  logic [PW-1:0]     sw_lvl,
  input  logic              ack,
  input  logic              ret,
  output logic              irq,
  output logic [IDW-1:0]    ack_id,
  output logic              chain,
  output logic [PW-1:0]     cur_lvl
);

  localparam int             DEPTH   = NSRC + 1;
  localparam int             SPW     = $clog2(DEPTH + 1);
  localparam logic [PW-1:0]  PMAX    = PW'(NSRC);
  localparam logic [PW-1:0]  NMI_LVL = PW'(NSRC + 1);
  localparam logic [IDW-1:0] SW_ID   = IDW'(NSRC);
  localparam logic [IDW-1:0] NMI_ID  = IDW'(NSRC + 1);
  localparam logic [IDW-1:0] NONE_ID = '1;
  localparam logic [SPW-1:0] FULL    = SPW'(DEPTH);

  function automatic logic [PW-1:0] sat(input logic [PW-1:0] v);
    return (v > PMAX) ? PMAX : v;
  endfunction

  logic [PW-1:0]  stk [DEPTH];
  logic [SPW-1:0] sp;
  logic           sw_pend;
  logic [PW-1:0]  sw_lvl_q;
  logic [PW-1:0]  win_lvl;
  logic [IDW-1:0] win_id;

  always_comb begin
    win_lvl = '0;
    win_id  = NONE_ID;
    for (int i = 0; i < NSRC; i++)
      if (req[i] && sat(src_lvl[i*PW +: PW]) > win_lvl) begin
        win_lvl = sat(src_lvl[i*PW +: PW]);
        win_id  = IDW'(i);
      end
    if (sw_pend && sw_lvl_q > win_lvl) begin
      win_lvl = sw_lvl_q;
      win_id  = SW_ID;
    end
    if (nmi) begin
      win_lvl = NMI_LVL;
      win_id  = NMI_ID;
    end
  end

  wire [PW-1:0] top    = (sp != '0) ? stk[sp - 1'b1] : '0;
  wire          take   = ack && irq;
  wire          do_ret = ret && !ack && (sp != '0);

  assign irq    = win_lvl > cur_lvl;
  assign chain  = do_ret && (win_lvl > top);
  assign ack_id = (take || chain) ? win_id : NONE_ID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl <= '0;
      sp      <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (take) begin
      stk[sp] <= cur_lvl;
      sp      <= sp + 1'b1;
      cur_lvl <= win_lvl;
    end else if (chain) begin
      cur_lvl <= win_lvl;
    end else if (do_ret) begin
      cur_lvl <= top;
      sp      <= sp - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_pend  <= 1'b0;
      sw_lvl_q <= '0;
    end else if (sw_wr) begin
      sw_pend  <= |sw_lvl;
      sw_lvl_q <= sat(sw_lvl);
    end else if ((take || chain) && win_id == SW_ID) begin
      sw_pend  <= 1'b0;
    end
  end

  a_r2_accept_raises: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cur_lvl > $past(cur_lvl));
  a_r3_return_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ret && !chain) |=> cur_lvl < $past(cur_lvl));
  a_r3_stack_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= FULL);
  a_r4_nmi_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi && cur_lvl != NMI_LVL) |-> irq);
  a_r4_nmi_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == NMI_LVL) |-> !irq);
  a_r7_chain_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    chain |=> sp == $past(sp));
  a_r8_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq) |=> ($stable(cur_lvl) && $stable(sp)));

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  req = 0;
  logic [31:0] src_lvl = 0;
  logic        nmi = 0, sw_wr = 0, ack = 0, ret = 0;
  logic [3:0]  sw_lvl = 0;
  logic        irq, chain;
  logic [3:0]  ack_id, cur_lvl;

  int checks = 0, fails = 0;
  int lv [8];
  int m_cur = 0, swp_m = 0, swl_m = 0;
  int m_stk [$];
  bit done = 0;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .src_lvl(src_lvl), .nmi(nmi),
    .sw_wr(sw_wr), .sw_lvl(sw_lvl), .ack(ack), .ret(ret), .irq(irq),
    .ack_id(ack_id), .chain(chain), .cur_lvl(cur_lvl));

  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_lv();
    for (int i = 0; i < 8; i++) src_lvl[i*4 +: 4] = 4'(lv[i]);
  endtask

  function automatic void ref_win(output int id, output int l);
    id = 15; l = 0;
    for (int i = 0; i < 8; i++)
      if (req[i] && (lv[i] > 8 ? 8 : lv[i]) > l) begin
        l = lv[i] > 8 ? 8 : lv[i]; id = i;
      end
    if (swp_m != 0 && swl_m > l) begin l = swl_m; id = 8; end
    if (nmi) begin l = 9; id = 9; end
  endfunction

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic chk_irq(string tag);
    int id, l;
    #1; ref_win(id, l);
    chk(tag, int'(irq), int'(l > m_cur));
  endtask

  task automatic do_ack(string tag);
    int id, l; bit e;
    ref_win(id, l); e = l > m_cur;
    ack = 1; #1;
    chk(tag, int'(ack_id), e ? id : 15);
    step(); ack = 0;
    if (e) begin m_stk.push_back(m_cur); m_cur = l; if (id == 8) swp_m = 0; end
    #1; chk(tag, int'(cur_lvl), m_cur);
  endtask

  task automatic do_ret(string tag);
    int id, l, t; bit ch;
    ref_win(id, l);
    t = m_stk.size() != 0 ? m_stk[$] : 0;
    ch = m_stk.size() != 0 && l > t;
    ret = 1; #1;
    chk(tag, int'(chain), int'(ch));
    chk(tag, int'(ack_id), ch ? id : 15);
    step(); ret = 0;
    if (ch) begin m_cur = l; if (id == 8) swp_m = 0; end
    else if (m_stk.size() != 0) m_cur = m_stk.pop_back();
    #1; chk(tag, int'(cur_lvl), m_cur);
  endtask

  task automatic sw_write(int v);
    sw_wr = 1; sw_lvl = 4'(v);
    step(); sw_wr = 0;
    swp_m = (v != 0); swl_m = v > 8 ? 8 : v;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    lv = '{3, 0, 7, 7, 2, 11, 5, 1};
    set_lv();
    repeat (3) @(posedge clk);
    #5 rst_n = 1; #1;
    chk("R9 irq", int'(irq), 0);
    chk("R9 cur", int'(cur_lvl), 0);
    chk("R9 chain", int'(chain), 0);
    chk("R9 id", int'(ack_id), 15);
    step();

    for (int p = 0; p < 256; p++) begin
      req = 8'(p);
      chk_irq("R1 sweep");
      do_ack("R2 sweep");
      req = 0;
      do_ret("R3 sweep");
    end

    for (int L = 1; L <= 9; L++) begin
      sw_write(L);
      chk_irq("R6 sw pend");
      do_ack("R6 sw ack");
      for (int p = 0; p < 256; p++) begin
        req = 8'(p);
        chk_irq("R1 level");
      end
      req = 0;
      chk_irq("R6 sw cleared");
      do_ret("R3 level");
    end

    sw_write(3); chk_irq("R6 set");
    sw_write(0); chk_irq("R6 cancel");

    req = 8'h10; chk_irq("R5 early"); step();
    req = 8'h14; do_ack("R5 late winner");
    req = 0; do_ret("R5 back");

    req = 8'h01; do_ack("R7 enter");
    req = 8'h10; chk_irq("R7 masked");
    do_ret("R7 chain");
    req = 0; do_ret("R7 unwind");
    sw_write(5); do_ack("R7 outer");
    req = 8'h04; do_ack("R7 inner");
    req = 8'h01; do_ret("R7 no chain");
    req = 0; do_ret("R7 out");
    req = 8'h04; do_ack("R7 hw");
    sw_write(4); req = 0;
    do_ret("R7 chain sw");
    do_ret("R7 sw done");
    chk_irq("R6 chained sw cleared");
    req = 8'h40; do_ack("R6 hw ack");
    do_ret("R6 hw still pending");
    req = 0; do_ret("R6 hw out");

    sw_write(8); do_ack("R4 at 8");
    req = 8'hFF; chk_irq("R4 blocked at 8");
    nmi = 1; chk_irq("R4 nmi req");
    do_ack("R4 nmi ack");
    chk_irq("R4 no reentry");
    nmi = 0; req = 0;
    do_ret("R4 back"); do_ret("R4 base");

    do_ack("R8 spurious");
    do_ret("R8 empty ret");

    lv = '{1, 2, 3, 4, 5, 6, 7, 8};
    set_lv();
    for (int i = 0; i < 8; i++) begin
      req[i] = 1'b1;
      do_ack("R3 nest");
    end
    nmi = 1; do_ack("R3 nest nmi");
    nmi = 0; req = 0;
    for (int i = 0; i < 9; i++) do_ret("R3 unwind");
    chk("R3 bottom", int'(cur_lvl), 0);

    req = 8'h04; ack = 1; ret = 1; #1;
    chk("R8 both chain", int'(chain), 0);
    chk("R8 both id", int'(ack_id), 2);
    step(); ack = 0; ret = 0;
    m_stk.push_back(0); m_cur = 3; #1;
    chk("R8 both cur", int'(cur_lvl), 3);
    req = 0; do_ret("R8 both out");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule